// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

The mailbox lets processors on one chip hand short messages to each other through a shared register space. It holds several independent channels. A processor first writes the global key to open the register space. It then claims a channel by writing a single vector bit as the channel's owner, loads up to eight message words and names the destination vectors. A send trigger makes the destination vectors pending and drives their interrupt lines. Once the receiver acknowledges, the owner clears the acknowledge interrupt and the channel is ready for the next message.

Each channel moves through four states: idle (no owner), ready (owned), busy (a message is in flight) and acknowledged. In automatic-acknowledge mode, a send reaches the acknowledged state one clock after the trigger. In manual mode, the channel stays busy until the receiver writes the destination-clear register. Each interrupt output is shared by all channels. A vector fires when any channel has that bit pending and unmasked.

The register port is a plain single-cycle bus: a write strobe with address and data, and read data that follows the address combinationally. It has no back-pressure, so every write completes in the clock edge on which it is strobed.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset the lock register at 0xA00 reads 1, every channel's mode register reads 0x10 (idle), every mask reads all ones over the vector width, and all interrupt outputs are low.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the block, and the lock register then reads 0. Any other value written there locks it again. While locked, writes to channel registers are ignored.
- R3: Channel c occupies 0x40·c to 0x40·c+0x3F. Writing a one-hot value to the source register (offset 0x00) while the channel is idle claims the channel: the source register reads the value back and mode reads 0x20 (bit 5, ready). A source write that is not one-hot, or that arrives while the channel is not idle, is ignored.
- R4: Writing zero to the source register of a ready channel releases it: source reads 0 and mode reads 0x10.
- R5: On a ready channel, writing the owner's bit to the send register (offset 0x1C) ORs the destination register (offset 0x04) into the pending bits, which read back at offset 0x0C, and the channel becomes busy (mode bits 4, 5 and 7 all clear). A send with any other value is ignored.
- R6: Mode bit 0 selects automatic acknowledge. With it set, the channel is busy for exactly one cycle after the send and then enters the acknowledged state (mode bit 7).
- R7: Writing to destination-clear (offset 0x08) clears the written pending bits. If the channel is busy in manual mode, the write also moves it to the acknowledged state (mode 0x80).
- R8: In the acknowledged state, writing a value that includes the owner's bit to interrupt-clear (offset 0x18) returns the channel to ready. A value without that bit is ignored.
- R9: Interrupt output v is high when any channel has bit v set in its pending bits, or in its owner bits while acknowledged, and bit v of that channel's mask (offset 0x14) is 0.
- R10: The eight message words at offsets 0x20 + 4·i are written and read back as full 32-bit values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NVEC | One interrupt line per vector |

## Verification
The assertions take for granted that every write is a single-cycle strobe whose address and data are settled before the clock edge. They also assume that software claims a channel with a one-hot value before sending, so the owner bits are always zero or one-hot. The stimulus drives the bus only on the falling edge, holds each write for exactly one rising edge, and reaches every state change through the documented register sequence. It also makes deliberate bad writes: a locked write, a non-one-hot source, a wrong send bit and a wrong clear bit. These exercise the ignore paths without breaking the one-hot owner assumption.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned MSG_WORDS = 8;
  localparam logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  localparam logic [5:0] OFF_SRC   = 6'h00;
  localparam logic [5:0] OFF_DST   = 6'h04;
  localparam logic [5:0] OFF_DCLR  = 6'h08;
  localparam logic [5:0] OFF_DSTAT = 6'h0C;
  localparam logic [5:0] OFF_MODE  = 6'h10;
  localparam logic [5:0] OFF_MASK  = 6'h14;
  localparam logic [5:0] OFF_ICLR  = 6'h18;
  localparam logic [5:0] OFF_SEND  = 6'h1C;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_BUSY  = 2'd2,
    ST_ACK   = 2'd3
  } chan_st_e;
endpackage

// File: rtl/mbx_lock.sv
module mbx_lock
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            locked_q <= 1'b1;
    else if (we_i && sel_i) locked_q <= (wdata_i != UNLOCK_KEY);
  end

  assign locked_o = locked_q;

  // R2: the key opens the block on the next cycle
  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && sel_i && wdata_i == UNLOCK_KEY) |=> !locked_o);
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
  import mbx_pkg::*;
#(
  parameter int unsigned NVEC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              locked_i,
  input  logic [5:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NVEC-1:0]   req_o
);
  localparam int unsigned WIDX_W = $clog2(MSG_WORDS);

  chan_st_e               st_q;
  logic [NVEC-1:0]        src_q, dst_q, pend_q, mask_q;
  logic                   auto_q;
  logic [DATA_W-1:0]      msg_q [MSG_WORDS];
  logic                   wr;
  logic [NVEC-1:0]        wv;
  logic                   wv_onehot;
  logic [WIDX_W-1:0]      widx;

  assign wr        = we_i && !locked_i;
  assign wv        = wdata_i[NVEC-1:0];
  assign wv_onehot = (wv != '0) && ((wv & (wv - 1'b1)) == '0);
  assign widx      = off_i[WIDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
      auto_q <= 1'b0;
      for (int i = 0; i < MSG_WORDS; i++) msg_q[i] <= '0;
    end else begin
      if (st_q == ST_BUSY && auto_q) st_q <= ST_ACK;
      if (wr) begin
        case (off_i)
          OFF_SRC: begin
            if (st_q == ST_IDLE && wv_onehot) begin
              src_q <= wv;
              st_q  <= ST_READY;
            end else if (st_q == ST_READY && wv == '0) begin
              src_q <= '0;
              st_q  <= ST_IDLE;
            end
          end
          OFF_DST:  dst_q  <= wv;
          OFF_DCLR: begin
            pend_q <= pend_q & ~wv;
            if (st_q == ST_BUSY) st_q <= ST_ACK;
          end
          OFF_MODE: auto_q <= wdata_i[0];
          OFF_MASK: mask_q <= wv;
          OFF_ICLR: if (st_q == ST_ACK && (wv & src_q) != '0) st_q <= ST_READY;
          OFF_SEND: begin
            if (st_q == ST_READY && wv == src_q) begin
              pend_q <= pend_q | dst_q;
              st_q   <= ST_BUSY;
            end
          end
          default: if (off_i[5]) msg_q[widx] <= wdata_i;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_SRC:   rdata_o = DATA_W'(src_q);
      OFF_DST:   rdata_o = DATA_W'(dst_q);
      OFF_DSTAT: rdata_o = DATA_W'(pend_q);
      OFF_MODE:  rdata_o = {24'd0, st_q == ST_ACK, 1'b0, st_q == ST_READY,
                            st_q == ST_IDLE, 3'd0, auto_q};
      OFF_MASK:  rdata_o = DATA_W'(mask_q);
      default:   if (off_i[5]) rdata_o = msg_q[widx];
    endcase
  end

  assign req_o = (pend_q | ((st_q == ST_ACK) ? src_q : '0)) & ~mask_q;

  // R2: locked writes leave configuration and state untouched
  assert_locked_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && locked_i && st_q != ST_BUSY) |=> ($stable(dst_q) && $stable(src_q) && $stable(st_q)));
  // R3: an owned channel always has exactly one owner bit
  assert_acquire_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> $onehot(src_q));
  // R5: a send makes every destination bit pending
  assert_send_pends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off_i == OFF_SEND && st_q == ST_READY && wv == src_q)
      |=> ((pend_q & $past(dst_q)) == $past(dst_q)) && st_q == ST_BUSY);
  // R6: automatic acknowledge leaves busy after one cycle
  assert_autoack_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY && auto_q) |=> st_q == ST_ACK);
  // R7: the acknowledged state is only entered from busy
  assert_ack_from_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK && $past(st_q) != ST_ACK) |-> $past(st_q) == ST_BUSY);
endmodule

// File: rtl/mbx_irq_or.sv
module mbx_irq_or #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned NVEC = 8
) (
  input  logic [NCH-1:0][NVEC-1:0] req_i,
  output logic [NVEC-1:0]          irq_o
);
  always_comb begin
    irq_o = '0;
    for (int c = 0; c < NCH; c++) irq_o = irq_o | req_i[c];
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned NCH  = 4,
  parameter int unsigned NVEC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NVEC-1:0]   irq_o
);
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic                      lock_sel, locked, chan_space;
  logic [4:0]                chidx;
  logic [NCH-1:0][NVEC-1:0]  req;
  logic [DATA_W-1:0]         chan_rd [NCH];

  assign lock_sel   = (bus_addr == LOCK_ADDR);
  assign chidx      = bus_addr[10:6];
  assign chan_space = !bus_addr[11] && (32'(chidx) < NCH);

  mbx_lock u_lock (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .sel_i(lock_sel),
    .wdata_i(bus_wdata), .locked_o(locked)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    mbx_chan #(.NVEC(NVEC)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .we_i(bus_we && chan_space && chidx == 5'(c)),
      .locked_i(locked), .off_i(bus_addr[5:0]), .wdata_i(bus_wdata),
      .rdata_o(chan_rd[c]), .req_o(req[c])
    );
  end

  mbx_irq_or #(.NCH(NCH), .NVEC(NVEC)) u_irq (.req_i(req), .irq_o(irq_o));

  always_comb begin
    if (lock_sel)        bus_rdata = {31'd0, locked};
    else if (chan_space) bus_rdata = chan_rd[chidx[CW-1:0]];
    else                 bus_rdata = '0;
  end
endmodule

// File: tb/sim_mbx_ctrl.sv
module sim_mbx_ctrl;
  localparam int NVEC = 8;
  localparam int NV = 57;
  localparam logic [1:0] OW = 2'd0, OR_ = 2'd1, OI = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NVEC-1:0] irq_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mbx_ctrl #(.NCH(4), .NVEC(NVEC)) u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  // {op, addr, data/expected, requirement number}
  localparam logic [49:0] TBL [NV] = '{
    {OR_, 12'hA00, 32'h1,        4'd1},  // R1 locked
    {OR_, 12'h010, 32'h10,       4'd1},  // R1 idle
    {OR_, 12'h014, 32'hFF,       4'd1},  // R1 mask
    {OI,  12'h000, 32'h0,        4'd1},  // R1 irq low
    {OW,  12'h000, 32'h1,        4'd2},  // R2 locked write
    {OR_, 12'h000, 32'h0,        4'd2},
    {OW,  12'hA00, 32'h1ACCE551, 4'd2},  // R2 unlock
    {OR_, 12'hA00, 32'h0,        4'd2},
    {OW,  12'h000, 32'h3,        4'd3},  // R3 not one-hot
    {OR_, 12'h000, 32'h0,        4'd3},
    {OW,  12'h000, 32'h4,        4'd3},  // R3 claim vec2
    {OR_, 12'h010, 32'h20,       4'd3},
    {OW,  12'h000, 32'h8,        4'd3},  // R3 not idle
    {OR_, 12'h000, 32'h4,        4'd3},
    {OW,  12'h004, 32'h10,       4'd5},  // dst vec4
    {OW,  12'h014, 32'hEF,       4'd9},  // unmask vec4
    {OW,  12'h01C, 32'h8,        4'd5},  // R5 wrong send
    {OR_, 12'h010, 32'h20,       4'd5},
    {OW,  12'h01C, 32'h4,        4'd5},  // R5 send
    {OR_, 12'h00C, 32'h10,       4'd5},
    {OR_, 12'h010, 32'h0,        4'd7},  // R7 busy holds
    {OI,  12'h000, 32'h10,       4'd9},  // R9 dst irq
    {OW,  12'h008, 32'h10,       4'd7},  // R7 dclr
    {OR_, 12'h010, 32'h80,       4'd7},
    {OR_, 12'h00C, 32'h0,        4'd7},
    {OI,  12'h000, 32'h0,        4'd9},  // R9 ack masked
    {OW,  12'h014, 32'hEB,       4'd9},
    {OI,  12'h000, 32'h4,        4'd9},  // R9 ack irq
    {OW,  12'h018, 32'h8,        4'd8},  // R8 wrong bit
    {OR_, 12'h010, 32'h80,       4'd8},
    {OW,  12'h018, 32'h4,        4'd8},  // R8 clear
    {OR_, 12'h010, 32'h20,       4'd8},
    {OI,  12'h000, 32'h0,        4'd9},
    {OW,  12'h040, 32'h2,        4'd3},  // ch1 claim vec1
    {OW,  12'h044, 32'h1,        4'd5},
    {OW,  12'h054, 32'h0,        4'd9},
    {OW,  12'h050, 32'h1,        4'd6},  // R6 auto mode
    {OW,  12'h05C, 32'h2,        4'd6},
    {OR_, 12'h050, 32'h01,       4'd6},  // R6 busy one cycle
    {OR_, 12'h050, 32'h81,       4'd6},  // R6 ack
    {OI,  12'h000, 32'h3,        4'd9},  // R9 dst + ack
    {OW,  12'h058, 32'h2,        4'd8},
    {OI,  12'h000, 32'h1,        4'd9},
    {OW,  12'h048, 32'h1,        4'd7},  // R7 dclr while ready
    {OI,  12'h000, 32'h0,        4'd9},
    {OW,  12'h020, 32'hDEADBEEF, 4'd10}, // R10
    {OW,  12'h03C, 32'h12345678, 4'd10},
    {OR_, 12'h020, 32'hDEADBEEF, 4'd10},
    {OR_, 12'h03C, 32'h12345678, 4'd10},
    {OR_, 12'h024, 32'h0,        4'd10},
    {OW,  12'h000, 32'h0,        4'd4},  // R4 release
    {OR_, 12'h010, 32'h10,       4'd4},
    {OR_, 12'h000, 32'h0,        4'd4},
    {OW,  12'hA00, 32'h0,        4'd2},  // R2 relock
    {OR_, 12'hA00, 32'h1,        4'd2},
    {OW,  12'h044, 32'hFF,       4'd2},
    {OR_, 12'h044, 32'h1,        4'd2}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_addr  = TBL[i][45:34];
      bus_wdata = TBL[i][33:2+2];
      bus_wdata = TBL[i][35:4];
      bus_addr  = TBL[i][47:36];
      bus_we    = (TBL[i][49:48] == OW);
      #1;
      if (TBL[i][49:48] == OR_) check(bus_rdata, TBL[i][35:4], int'(TBL[i][3:0]));
      if (TBL[i][49:48] == OI)  check(32'(irq_o), TBL[i][35:4], int'(TBL[i][3:0]));
      @(posedge clk);
      #1 bus_we = 1'b0;
    end
    // R1: reset in mid-run restores the reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 12'hA00; #1 check(bus_rdata, 32'h1, 1);
    bus_addr = 12'h050; #1 check(bus_rdata, 32'h10, 1);
    bus_addr = 12'h014; #1 check(bus_rdata, 32'hFF, 1);
    check(32'(irq_o), 32'h0, 1);
    finish_run();
  end
endmodule